// File: doc/BRIEF.md
# CAN Fault Confinement Counters

This block keeps the two error tallies of a CAN node, one for faults seen while receiving and one for faults seen while transmitting, and turns them into the node's fault confinement standing. Its job is to keep a node that misbehaves from disturbing the bus any longer than necessary. The node is error active while both tallies are low and error passive once either grows large. It goes bus off when the transmit tally runs past its top threshold.

The tallies move only when the frame sequencer sends a single-cycle command pulse. The commands are receive fault, transmit fault, clean receive, clean transmit, and "eleven recessive bits observed". Which protocol event raises which command is decided outside this block. The node state is not stored separately: it is decoded from the two tally values on every cycle.

While the node is bus off, the normal commands are ignored. A separate counter tallies the recessive-idle events, and once enough have been seen both tallies return to zero, which puts the node back into error active. A synchronous init input clears everything at any time.

Top module: `can_fault_guard`

## Requirements
- R1: After reset, and in the cycle after `init` is high, both tallies read 0, `node_state` reads error active and `warn` is low; `init` overrides every other command in the same cycle.
- R2: Outside bus off, a `tx_err` pulse adds 8 to `tec_val` and an `rx_err` pulse adds 1 to `rec_val`, visible after the next rising clock edge; `rec_val` saturates at all ones (511 with the default width).
- R3: Outside bus off, `tx_ok` subtracts 1 from `tec_val` and `rx_ok` subtracts 1 from `rec_val`; a tally already at 0 stays at 0.
- R4: For one tally, an error pulse takes precedence over a success pulse in the same cycle, and the receive and transmit tallies respond independently to commands arriving together.
- R5: `node_state` uses 2'b00 for error active, 2'b01 for error passive and 2'b10 for bus off, and never shows 2'b11. It reads error passive when either tally is 128 or more while `tec_val` is below 256, and error active when both tallies are below 128.
- R6: `node_state` reads bus off whenever `tec_val` is 256 or more.
- R7: While bus off, `rx_err`, `tx_err`, `rx_ok` and `tx_ok` leave both tallies unchanged.
- R8: While bus off, the 128th `idle11` pulse clears both tallies, so the node reads error active after that edge; after 127 pulses it is still bus off. An `idle11` pulse outside bus off has no effect on the tallies.
- R9: `warn` is high exactly when either tally is 96 or more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| init | input | 1 | Synchronous clear of all tallies and of the recovery count |
| rx_err | input | 1 | Receive fault command pulse |
| tx_err | input | 1 | Transmit fault command pulse |
| rx_ok | input | 1 | Clean receive command pulse |
| tx_ok | input | 1 | Clean transmit command pulse |
| idle11 | input | 1 | Eleven recessive bits observed |
| rec_val | output | CNT_W | Receive error tally |
| tec_val | output | CNT_W | Transmit error tally |
| node_state | output | 2 | Fault confinement state code |
| warn | output | 1 | Either tally at or above the warning level |

## Verification
The bench instantiates the block with its default parameters: 9-bit tallies, a warning level of 96, a passive level of 128, a bus-off level of 256 and 128 recovery events. These values are small enough that a few hundred commands carry the transmit tally through every threshold and the 511 saturation point of the receive tally. A weighted random stream, heavy on transmit faults and idle events, therefore cycles through bus off and recovery many times. Directed sequences land exactly on 95/96, 127/128, the 127th and 128th recovery events, and the colliding-command cases.

// File: rtl/fcg_pkg.sv
package fcg_pkg;
  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'b00,
    FC_PASSIVE = 2'b01,
    FC_BUSOFF  = 2'b10
  } fc_state_e;
endpackage

// File: rtl/fcg_err_counter.sv
// Saturating up/down error tally with clear and freeze controls.
module fcg_err_counter #(
  parameter int CNT_W = 9,
  parameter int STEP  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             hold,
  input  logic             bump,
  input  logic             drop,
  output logic [CNT_W-1:0] val
);
  localparam logic [CNT_W-1:0] MAXV   = '1;
  localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP);
  localparam logic [CNT_W-1:0] HEAD   = MAXV - STEP_V;
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

  logic [CNT_W-1:0] nxt;

  always_comb begin
    nxt = val;
    if (clr) begin
      nxt = '0;
    end else if (!hold) begin
      if (bump) begin
        nxt = (val > HEAD) ? MAXV : val + STEP_V;
      end else if (drop && val != '0) begin
        nxt = val - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val <= '0;
    else        val <= nxt;
  end
endmodule

// File: rtl/fcg_recovery.sv
// Counts recessive-idle events while bus off and flags the last one.
module fcg_recovery #(
  parameter int RECOVER_CNT = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bus_off,
  input  logic tick,
  output logic done
);
  localparam int RW = $clog2(RECOVER_CNT + 1);
  localparam logic [RW-1:0] LAST = RW'(RECOVER_CNT - 1);
  localparam logic [RW-1:0] ONE  = RW'(1);

  logic [RW-1:0] cnt;

  assign done = bus_off && tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr || !bus_off || done) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= cnt + ONE;
    end
  end
endmodule

// File: rtl/fcg_state_decode.sv
// Derives the confinement state and warning from the two tallies.
module fcg_state_decode #(
  parameter int CNT_W       = 9,
  parameter int WARN_LVL    = 96,
  parameter int PASSIVE_LVL = 128,
  parameter int BUSOFF_LVL  = 256
) (
  input  logic [CNT_W-1:0] rec,
  input  logic [CNT_W-1:0] tec,
  output fcg_pkg::fc_state_e state,
  output logic             warn,
  output logic             bus_off
);
  localparam logic [CNT_W-1:0] WARN_V = CNT_W'(WARN_LVL);
  localparam logic [CNT_W-1:0] PASS_V = CNT_W'(PASSIVE_LVL);
  localparam logic [CNT_W-1:0] OFF_V  = CNT_W'(BUSOFF_LVL);

  logic passive;

  assign bus_off = (tec >= OFF_V);
  assign passive = (tec >= PASS_V) || (rec >= PASS_V);
  assign warn    = (tec >= WARN_V) || (rec >= WARN_V);

  always_comb begin
    if (bus_off)      state = fcg_pkg::FC_BUSOFF;
    else if (passive) state = fcg_pkg::FC_PASSIVE;
    else              state = fcg_pkg::FC_ACTIVE;
  end
endmodule

// File: rtl/can_fault_guard.sv
module can_fault_guard #(
  parameter int CNT_W       = 9,
  parameter int TX_STEP     = 8,
  parameter int RX_STEP     = 1,
  parameter int WARN_LVL    = 96,
  parameter int PASSIVE_LVL = 128,
  parameter int BUSOFF_LVL  = 256,
  parameter int RECOVER_CNT = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             rx_err,
  input  logic             tx_err,
  input  logic             rx_ok,
  input  logic             tx_ok,
  input  logic             idle11,
  output logic [CNT_W-1:0] rec_val,
  output logic [CNT_W-1:0] tec_val,
  output logic [1:0]       node_state,
  output logic             warn
);
  fcg_pkg::fc_state_e st;
  logic bus_off;
  logic rec_done;
  logic wipe;

  assign wipe = init || rec_done;

  fcg_err_counter #(.CNT_W(CNT_W), .STEP(RX_STEP)) u_rx_cnt (
    .clk(clk), .rst_n(rst_n), .clr(wipe), .hold(bus_off),
    .bump(rx_err), .drop(rx_ok), .val(rec_val)
  );

  fcg_err_counter #(.CNT_W(CNT_W), .STEP(TX_STEP)) u_tx_cnt (
    .clk(clk), .rst_n(rst_n), .clr(wipe), .hold(bus_off),
    .bump(tx_err), .drop(tx_ok), .val(tec_val)
  );

  fcg_recovery #(.RECOVER_CNT(RECOVER_CNT)) u_recov (
    .clk(clk), .rst_n(rst_n), .clr(init), .bus_off(bus_off),
    .tick(idle11), .done(rec_done)
  );

  fcg_state_decode #(
    .CNT_W(CNT_W), .WARN_LVL(WARN_LVL),
    .PASSIVE_LVL(PASSIVE_LVL), .BUSOFF_LVL(BUSOFF_LVL)
  ) u_dec (
    .rec(rec_val), .tec(tec_val), .state(st), .warn(warn), .bus_off(bus_off)
  );

  assign node_state = st;
endmodule

// File: rtl/fcg_checker.sv
module fcg_checker #(
  parameter int CNT_W       = 9,
  parameter int TX_STEP     = 8,
  parameter int WARN_LVL    = 96,
  parameter int PASSIVE_LVL = 128,
  parameter int BUSOFF_LVL  = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic             init,
  input logic             rx_err,
  input logic             tx_err,
  input logic             rx_ok,
  input logic             tx_ok,
  input logic             idle11,
  input logic [CNT_W-1:0] rec_val,
  input logic [CNT_W-1:0] tec_val,
  input logic [1:0]       node_state,
  input logic             warn
);
  localparam logic [1:0] S_OFF = 2'b10;
  localparam logic [CNT_W-1:0] STEP_V = CNT_W'(TX_STEP);
  localparam logic [CNT_W-1:0] OFF_V  = CNT_W'(BUSOFF_LVL);
  localparam logic [CNT_W-1:0] PASS_V = CNT_W'(PASSIVE_LVL);
  localparam logic [CNT_W-1:0] WARN_V = CNT_W'(WARN_LVL);

  assert_init_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (tec_val == '0 && rec_val == '0 && node_state == 2'b00));

  assert_tx_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && node_state != S_OFF && tx_err) |=> (tec_val == $past(tec_val) + STEP_V));

  assert_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && tx_ok && !tx_err && tec_val == '0) |=> (tec_val == '0));

  assert_err_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && node_state != S_OFF && rx_err && rx_ok && rec_val != '1) |=> (rec_val > $past(rec_val)));

  assert_code_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    node_state != 2'b11);

  assert_passive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (node_state == 2'b01) |-> ((tec_val >= PASS_V || rec_val >= PASS_V) && tec_val < OFF_V));

  assert_busoff_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tec_val >= OFF_V) |-> (node_state == S_OFF));

  assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (node_state == S_OFF && !init && !idle11) |=> ($stable(tec_val) && $stable(rec_val)));

  assert_exit_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (node_state == S_OFF) |=> (node_state == S_OFF || (tec_val == '0 && rec_val == '0)));

  assert_warn_R9: assert property (@(posedge clk) disable iff (!rst_n)
    warn |-> (tec_val >= WARN_V || rec_val >= WARN_V));
endmodule

bind can_fault_guard fcg_checker #(
  .CNT_W(CNT_W), .TX_STEP(TX_STEP), .WARN_LVL(WARN_LVL),
  .PASSIVE_LVL(PASSIVE_LVL), .BUSOFF_LVL(BUSOFF_LVL)
) u_fcg_chk (
  .clk(clk), .rst_n(rst_n), .init(init), .rx_err(rx_err), .tx_err(tx_err),
  .rx_ok(rx_ok), .tx_ok(tx_ok), .idle11(idle11), .rec_val(rec_val),
  .tec_val(tec_val), .node_state(node_state), .warn(warn)
);

// File: tb/tb_can_fault_guard.sv
`timescale 1ns/1ps
module tb_can_fault_guard;
  localparam int CW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init = 1'b0, rx_err = 1'b0, tx_err = 1'b0, rx_ok = 1'b0, tx_ok = 1'b0, idle11 = 1'b0;
  logic [CW-1:0] rec_val, tec_val;
  logic [1:0] node_state;
  logic warn;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  int m_tec = 0, m_rec = 0, m_rcnt = 0;

  always #10 clk = ~clk;

  can_fault_guard #(
    .CNT_W(CW), .TX_STEP(8), .RX_STEP(1), .WARN_LVL(96),
    .PASSIVE_LVL(128), .BUSOFF_LVL(256), .RECOVER_CNT(128)
  ) dut (
    .clk(clk), .rst_n(rst_n), .init(init), .rx_err(rx_err), .tx_err(tx_err),
    .rx_ok(rx_ok), .tx_ok(tx_ok), .idle11(idle11), .rec_val(rec_val),
    .tec_val(tec_val), .node_state(node_state), .warn(warn)
  );

  function automatic logic [1:0] exp_state(int t, int r);
    if (t >= 256) return 2'b10;
    if (t >= 128 || r >= 128) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic exp_warn(int t, int r);
    return (t >= 96 || r >= 96);
  endfunction

  task automatic model_step(bit ini, bit re, bit te, bit ro, bit to, bit idl);
    if (ini) begin
      m_tec = 0; m_rec = 0; m_rcnt = 0;
    end else if (m_tec >= 256) begin
      if (idl) begin
        if (m_rcnt == 127) begin
          m_tec = 0; m_rec = 0; m_rcnt = 0;
        end else begin
          m_rcnt++;
        end
      end
    end else begin
      if (te) m_tec = m_tec + 8;
      else if (to && m_tec > 0) m_tec--;
      if (re) m_rec = (m_rec >= 511) ? 511 : m_rec + 1;
      else if (ro && m_rec > 0) m_rec--;
      m_rcnt = 0;
    end
  endtask

  task automatic chk(string tag);
    logic [1:0] es;
    logic ew;
    es = exp_state(m_tec, m_rec);
    ew = exp_warn(m_tec, m_rec);
    checks++;
    if (tec_val != CW'(m_tec) || rec_val != CW'(m_rec) || node_state != es || warn != ew) begin
      fails++;
      $display("FAIL %s: tec=%0d rec=%0d state=%0d warn=%0b expected tec=%0d rec=%0d state=%0d warn=%0b",
               tag, tec_val, rec_val, node_state, warn, m_tec, m_rec, es, ew);
    end
  endtask

  task automatic step(bit ini, bit re, bit te, bit ro, bit to, bit idl);
    @(negedge clk);
    init = ini; rx_err = re; tx_err = te; rx_ok = ro; tx_ok = to; idle11 = idl;
    @(posedge clk);
    model_step(ini, re, te, ro, to, idl);
    #2;
    init = 0; rx_err = 0; tx_err = 0; rx_ok = 0; tx_ok = 0; idle11 = 0;
  endtask

  task automatic fin();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      fin();
    end
  end

  initial begin
    void'($urandom(32'h5a17));
    repeat (3) @(negedge clk);
    chk("R1 reset");
    rst_n = 1'b1;

    // R2/R9: warning boundary at 96 (11 and 12 transmit faults)
    for (int i = 0; i < 11; i++) step(0, 0, 1, 0, 0, 0);
    chk("R2 tec 88");
    step(0, 0, 1, 0, 0, 0);
    chk("R9 warn at 96");
    step(0, 0, 0, 0, 1, 0);
    chk("R9 warn off at 95");

    // R5: receive tally to 127 then 128
    step(1, 0, 0, 0, 0, 0);
    chk("R1 init");
    for (int i = 0; i < 127; i++) step(0, 1, 0, 0, 0, 0);
    chk("R5 rec 127 active");
    step(0, 1, 0, 0, 0, 0);
    chk("R5 rec 128 passive");
    step(0, 0, 0, 1, 0, 0);
    chk("R5 back to active");

    // R4: collisions
    step(0, 1, 1, 1, 1, 0);
    chk("R4 error beats success");
    step(0, 0, 1, 1, 0, 0);
    chk("R4 independent tallies");

    // R3: floor at zero
    step(1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 1, 0);
    chk("R3 floor");
    step(0, 0, 0, 0, 0, 1);
    chk("R8 idle ignored when not bus off");

    // R6/R7: into bus off, commands ignored
    for (int i = 0; i < 32; i++) step(0, 0, 1, 0, 0, 0);
    chk("R6 bus off at 256");
    step(0, 1, 1, 1, 1, 0);
    chk("R7 commands ignored");

    // R8: recovery boundary
    for (int i = 0; i < 127; i++) step(0, 0, 0, 0, 0, 1);
    chk("R8 still bus off after 127");
    step(0, 0, 0, 0, 0, 1);
    chk("R8 recovered after 128");

    // R1: init in bus off
    for (int i = 0; i < 33; i++) step(0, 0, 1, 0, 0, 0);
    step(1, 1, 1, 0, 0, 1);
    chk("R1 init overrides");

    // R2: receive saturation
    for (int i = 0; i < 515; i++) step(0, 1, 0, 0, 0, 0);
    chk("R2 rec saturates");
    step(1, 0, 0, 0, 0, 0);

    // random mix
    for (int i = 0; i < 6000; i++) begin
      int r;
      bit ini, re, te, ro, to, idl;
      r = $urandom_range(0, 999);
      ini = (r < 3);
      re  = ($urandom_range(0, 3) == 0);
      te  = ($urandom_range(0, 2) == 0);
      ro  = ($urandom_range(0, 1) == 0);
      to  = ($urandom_range(0, 2) == 0);
      idl = ($urandom_range(0, 1) == 0);
      step(ini, re, te, ro, to, idl);
      chk("R2 R3 R5 R6 R7 R8 random");
    end

    finished = 1'b1;
    fin();
  end
endmodule